// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one starting column address into the column address for every beat of an SDRAM burst. A one-cycle `start_i` pulse captures the start column, a burst-length code and an order select. From the next cycle on, the block presents one column per clock on `col_o` while `valid_o` is high. On the final beat of a finite burst it raises `last_o`.

Finite bursts of 2, 4 or 8 beats stay inside a block of columns aligned to the burst length. Only the low log2(length) bits move, and the bits above them keep the start value. Those low bits either count upward with wraparound (sequential order) or are the start bits XORed with the beat number (interleaved order). A full-page burst steps through the whole column space one address at a time, wraps past the top, and never ends by itself. A `stop_i` strobe ends any burst early.

The block is intended to sit between a command sequencer, which issues the column command and handles banks and rows, and the column-address pins. It contains no data path.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are 0 until the first `start_i`.
- R2: A `start_i` pulse at a clock edge makes `valid_o` 1 from the next cycle on, and in that cycle `col_o` equals the `col_i` that was sampled with the start.
- R3: In sequential order (`ilv_i`=0), beat n of a finite burst of length L has low log2(L) bits equal to (start + n) mod L, and the bits above them equal those of the start column.
- R4: In interleaved order (`ilv_i`=1), beat n of a finite burst of length L has low log2(L) bits equal to the start's low bits XOR n, and the upper bits are held. For example, L=8 with start low bits 2 gives 2,3,0,1,6,7,4,5.
- R5: The length code `blen_i` maps as follows: 0 is 1 beat, 1 is 2 beats, 2 is 4 beats, 3 is 8 beats, and 7 is full page. Codes 4, 5 and 6 behave as 1 beat.
- R6: `last_o` is 1 only on the final beat of a finite burst. `valid_o` is 0 in the cycle after that beat unless a new start arrives.
- R7: A full-page burst (code 7) advances `col_o` by 1 each cycle, wraps modulo 2^COL_W, never raises `last_o`, and keeps running until it is stopped or restarted.
- R8: A full-page request with `ilv_i`=1 is carried out in sequential order.
- R9: `stop_i` during a burst makes `valid_o` 0 from the next cycle. `stop_i` while idle has no effect. `start_i` takes precedence over `stop_i` in the same cycle.
- R10: A `start_i` during a running burst abandons that burst and begins the new one from beat 0 with the new parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the inputs below |
| col_i | input | COL_W | Starting column |
| blen_i | input | 3 | Burst length code |
| ilv_i | input | 1 | 1 selects interleaved order |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
Finite bursts are run with start columns whose low bits are nonzero and whose upper bits are set. This shows whether only the aligned low bits wrap and whether the upper bits are held. The same start columns are run in both orders, so an adder cannot stand in for the XOR, or the reverse. Start columns whose low bits are zero give the same sequence in both orders, so they are avoided wherever order is being tested. A full-page burst started near the top of the page shows the wrap through zero and the absence of a final beat. A full-page request with interleaved order shows the forced sequential stepping. Early stops, an idle stop, reserved length codes and a restart mid-burst cover the remaining cases.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       blen_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam logic [2:0] CODE_FULL = 3'd7;

  logic             active_q, full_q, ilv_q;
  logic [COL_W-1:0] base_q, mask_q, cnt_q, mask_d, low;

  always_comb begin
    case (blen_i)
      3'd1:      mask_d = COL_W'(1);
      3'd2:      mask_d = COL_W'(3);
      3'd3:      mask_d = COL_W'(7);
      CODE_FULL: mask_d = '1;
      default:   mask_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      base_q   <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= (blen_i == CODE_FULL);
      ilv_q    <= ilv_i && (blen_i != CODE_FULL);
      base_q   <= col_i;
      mask_q   <= mask_d;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (stop_i || last_o) active_q <= 1'b0;
      else                  cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign low     = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign col_o   = (base_q & ~mask_q) | (low & mask_q);
  assign valid_o = active_q;
  assign last_o  = active_q && !full_q && (cnt_q == mask_q);
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             stop_i,
  input logic [2:0]       blen_i,
  input logic [COL_W-1:0] col_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic page_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       page_q <= 1'b0;
    else if (start_i) page_q <= (blen_i == 3'd7);

  AST_START_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o); // R2
  AST_START_COL: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (col_o == $past(col_i))); // R2
  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o); // R6
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o); // R6
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !valid_o); // R9
  AST_PAGE_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q && valid_o) |-> !last_o); // R7
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q && valid_o && !stop_i && !start_i) |=> (valid_o && col_o == $past(col_o) + 1'b1)); // R8
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .blen_i(blen_i),
  .col_i(col_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
);

// File: tb/sdram_burst_colgen_tb.sv
`timescale 1ns/1ps
module sdram_burst_colgen_tb_top;
  localparam int W = 9;

  typedef struct packed {
    logic [W-1:0]       col;
    logic [2:0]         bl;
    logic               il;
    logic [3:0]         len;
    logic [0:7][W-1:0]  exp;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{col:9'd162, bl:3'd3, il:1'b1, len:4'd8, exp:'{9'd162,9'd163,9'd160,9'd161,9'd166,9'd167,9'd164,9'd165}},
    '{col:9'd162, bl:3'd3, il:1'b0, len:4'd8, exp:'{9'd162,9'd163,9'd164,9'd165,9'd166,9'd167,9'd160,9'd161}},
    '{col:9'd13,  bl:3'd3, il:1'b1, len:4'd8, exp:'{9'd13,9'd12,9'd15,9'd14,9'd9,9'd8,9'd11,9'd10}},
    '{col:9'd501, bl:3'd2, il:1'b0, len:4'd4, exp:'{9'd501,9'd502,9'd503,9'd500,9'd0,9'd0,9'd0,9'd0}},
    '{col:9'd501, bl:3'd2, il:1'b1, len:4'd4, exp:'{9'd501,9'd500,9'd503,9'd502,9'd0,9'd0,9'd0,9'd0}},
    '{col:9'd7,   bl:3'd1, il:1'b0, len:4'd2, exp:'{9'd7,9'd6,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0}},
    '{col:9'd300, bl:3'd0, il:1'b0, len:4'd1, exp:'{9'd300,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0}},
    '{col:9'd45,  bl:3'd5, il:1'b1, len:4'd1, exp:'{9'd45,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0}},
    '{col:9'd46,  bl:3'd4, il:1'b0, len:4'd1, exp:'{9'd46,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0}},
    '{col:9'd511, bl:3'd6, il:1'b0, len:4'd1, exp:'{9'd511,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0,9'd0}}
  };

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, ilv_i = 1'b0, stop_i = 1'b0;
  logic [W-1:0] col_i = '0;
  logic [2:0] blen_i = '0;
  logic [W-1:0] col_o;
  logic valid_o, last_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i), .blen_i(blen_i),
    .ilv_i(ilv_i), .stop_i(stop_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic kick(input int c, input int bl, input bit il);
    start_i = 1'b1; col_i = W'(c); blen_i = 3'(bl); ilv_i = il;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(valid_o), 0);
    chk("R1 last", int'(last_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", int'(valid_o), 0);

    for (int v = 0; v < 10; v++) begin
      kick(int'(VEC[v].col), int'(VEC[v].bl), VEC[v].il);
      for (int n = 0; n < int'(VEC[v].len); n++) begin
        chk($sformatf("R2 valid v%0d b%0d", v, n), int'(valid_o), 1);
        chk($sformatf("R3/R4/R5 col v%0d b%0d", v, n), int'(col_o), int'(VEC[v].exp[n]));
        chk($sformatf("R6 last v%0d b%0d", v, n), int'(last_o), int'(n == int'(VEC[v].len) - 1));
        @(negedge clk);
      end
      chk($sformatf("R6 ends v%0d", v), int'(valid_o), 0);
    end

    // R7: full page from 510 wraps through zero, no last
    kick(510, 7, 1'b0);
    for (int n = 0; n < 600; n++) begin
      chk("R7 valid", int'(valid_o), 1);
      chk("R7 col", int'(col_o), (510 + n) % 512);
      chk("R7 last", int'(last_o), 0);
      @(negedge clk);
    end
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    chk("R9 stop full page", int'(valid_o), 0);

    // R8: full page with interleave runs sequentially
    kick(3, 7, 1'b1);
    for (int n = 0; n < 12; n++) begin
      chk("R8 col", int'(col_o), 3 + n);
      @(negedge clk);
    end
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    chk("R9 stop", int'(valid_o), 0);

    // R9: early stop in an 8-beat burst
    kick(162, 3, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R9 mid col", int'(col_o), 164);
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0;
    chk("R9 early stop", int'(valid_o), 0);
    chk("R9 early stop last", int'(last_o), 0);

    // R9: stop while idle has no effect
    stop_i = 1'b1; @(negedge clk); stop_i = 1'b0; @(negedge clk);
    chk("R9 idle stop", int'(valid_o), 0);
    kick(7, 1, 1'b0);
    chk("R9 burst after idle stop", int'(col_o), 7);
    @(negedge clk);
    chk("R9 burst after idle stop b1", int'(col_o), 6);
    @(negedge clk);

    // R9: start beats stop in the same cycle
    stop_i = 1'b1; kick(20, 1, 1'b0); stop_i = 1'b0;
    chk("R9 start wins", int'(valid_o), 1);
    chk("R9 start wins col", int'(col_o), 20);
    @(negedge clk); @(negedge clk);

    // R10: restart mid-burst
    kick(0, 3, 1'b0);
    @(negedge clk);
    chk("R10 pre col", int'(col_o), 1);
    kick(100, 1, 1'b0);
    chk("R10 col b0", int'(col_o), 100);
    chk("R10 last b0", int'(last_o), 0);
    @(negedge clk);
    chk("R10 col b1", int'(col_o), 101);
    chk("R10 last b1", int'(last_o), 1);
    @(negedge clk);
    chk("R10 ends", int'(valid_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule